// File: doc/BRIEF.md
# Vertical Reference Line Counter with Active-Start Marker

This block follows the vertical timing of an incoming interlaced video stream and marks the first line of picture content in each field. It supports both 625-line/50 Hz and 525-line/60 Hz timing. It takes its vertical reference from one of four places: either edge of a vertical sync pin, a field-identity pin, or start-of-line words that an upstream parser has already decoded and that carry V (vertical blanking) and F (field) bits.

When the chosen reference event occurs, a line counter clears to zero. The counter then advances on each line strobe. The block holds the current field parity. It compares the count against a distance taken from a small table, chosen by reference source, line standard and field parity. When they match, it raises a marker for exactly that one line.

A change of configuration in the middle of a field silences the marker until the next reference event. The counter stops at its largest value rather than wrapping. Pin inputs are synchronised inside the block.

Top module: `vline_anchor`

## Requirements
- R1: `mode_i` picks the reference. Code 7 uses the start-of-line words. Code 6 uses either edge of the field-identity pin. Codes 1, 3 and 5 use the falling edge of the vertical sync pin. Codes 0, 2 and 4 use its rising edge.
- R2: For the 625-line standard (`std_525_i`=0), the marker line number is as follows. Falling sync edge: 24 for an odd field, 25 for an even field. Start-of-line words: 15 odd, 16 even. Field-identity pin: 15 odd, 16 even. Rising sync edge: 21 odd, 22 even.
- R3: For the 525-line standard (`std_525_i`=1), the marker line number is as follows. Falling sync edge: 22 for both fields. Start-of-line words: 12 odd, 13 even. Field-identity pin: 12 odd, 13 even. Rising sync edge: 18 odd, 19 even.
- R4: A reference event sets `line_cnt_o` to 0. After that, each cycle with `line_stb_i`=1 adds one. With no strobe, the count holds.
- R5: `active_start_o` is 1 only while `line_cnt_o` equals the table entry for the current source, standard and `field_even_o`. It lasts for exactly one line.
- R6: In mode 7, the reference event is a decoded word (`sav_stb_i`=1) whose V bit is 1 after the previous word had V=0. The F bit of that word becomes `field_even_o`, with 1 meaning even. Further words with V=1 do not reset the count.
- R7: In mode 6, each edge of `fid_i` is a reference event, and the new pin level becomes `field_even_o` (1 = even).
- R8: In the falling-edge sync modes, `field_even_o` takes the level of `fid_i` at the falling edge.
- R9: In the rising-edge sync modes, `field_even_o` takes the `fid_i` level that was captured at the most recent falling edge of the sync pin. The pin level at the rising edge itself is not used.
- R10: A change of `mode_i` or `std_525_i` keeps `active_start_o` low until the next reference event.
- R11: `line_cnt_o` stops at 1023 and does not wrap.
- R12: After reset, `line_cnt_o`=0, `field_even_o`=0 and `active_start_o`=0, and no marker appears before the first reference event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle strobe per video line |
| vs_i | input | 1 | Vertical sync pin (asynchronous) |
| fid_i | input | 1 | Field-identity pin, 1 = even (asynchronous) |
| sav_stb_i | input | 1 | A decoded start-of-line word is valid |
| sav_v_i | input | 1 | V bit of the decoded word |
| sav_f_i | input | 1 | F bit of the decoded word |
| mode_i | input | 3 | Reference source select |
| std_525_i | input | 1 | 1 = 525-line standard, 0 = 625-line standard |
| field_even_o | output | 1 | Current field parity, 1 = even |
| line_cnt_o | output | 10 | Lines since the last reference event |
| active_start_o | output | 1 | High for the first active line |

## Verification
Each reference source is driven under both line standards and both field parities, and the marker is checked on every line from 1 to 30 after the event. This separates the eight table entries from one another. The rising-edge sync case changes the field-identity pin between the falling and rising edges, which tells apart a design that captures parity at the falling edge from one that samples it at the rising edge. Repeated V=1 words, a configuration change in the middle of a field, and a long run of strobes with no event test resets that must not happen, suppression of the marker and saturation of the count.

// File: rtl/vla_pkg.sv
package vla_pkg;

    localparam int OFS_W = 5;

    typedef enum logic [1:0] {
        SRC_VS_RISE,
        SRC_VS_FALL,
        SRC_EMB,
        SRC_FID
    } ref_src_e;

    function automatic ref_src_e decode_mode(input logic [2:0] m);
        if (m == 3'd7)      return SRC_EMB;
        else if (m == 3'd6) return SRC_FID;
        else if (m[0])      return SRC_VS_FALL;
        else                return SRC_VS_RISE;
    endfunction

    // distance from reference event to first picture line
    function automatic logic [OFS_W-1:0] line_offset(input ref_src_e s,
                                                     input logic is525,
                                                     input logic even);
        logic [OFS_W-1:0] base;
        logic             step;
        step = even;
        case (s)
            SRC_VS_FALL: begin
                base = is525 ? 5'd22 : 5'd24;
                step = is525 ? 1'b0 : even;
            end
            SRC_VS_RISE: base = is525 ? 5'd18 : 5'd21;
            default:     base = is525 ? 5'd12 : 5'd15;
        endcase
        return base + {{(OFS_W-1){1'b0}}, step};
    endfunction

endpackage

// File: rtl/vla_pin_edge.sv
module vla_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic              rise;
        logic              fall;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[STAGES-1];
        st_d.rise = st_q.sync[STAGES-1] & ~st_q.prev;
        st_d.fall = ~st_q.sync[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.prev;
    assign rise_o  = st_q.rise;
    assign fall_o  = st_q.fall;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));                            // R1

    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> level_o);                                    // R1

endmodule

// File: rtl/vline_anchor.sv
module vline_anchor
    import vla_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter bit USE_FID_PIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb_i,
    input  logic             vs_i,
    input  logic             fid_i,
    input  logic             sav_stb_i,
    input  logic             sav_v_i,
    input  logic             sav_f_i,
    input  logic [2:0]       mode_i,
    input  logic             std_525_i,
    output logic             field_even_o,
    output logic [CNT_W-1:0] line_cnt_o,
    output logic             active_start_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             field;
        logic             par_fall;
        logic             active;
        logic [2:0]       mode;
        logic             std;
        logic             v_prev;
        logic             emb_ev;
        logic             emb_f;
    } anchor_st_t;

    anchor_st_t st_d, st_q;

    logic vs_lvl, vs_rise, vs_fall;
    logic fid_lvl, fid_rise, fid_fall;
    logic ref_ev, new_field, fid_par, cfg_chg;
    ref_src_e src;

    vla_pin_edge #(.STAGES(SYNC_STAGES)) u_vs_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(vs_i),
        .level_o(vs_lvl), .rise_o(vs_rise), .fall_o(vs_fall)
    );

    vla_pin_edge #(.STAGES(SYNC_STAGES)) u_fid_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(fid_i),
        .level_o(fid_lvl), .rise_o(fid_rise), .fall_o(fid_fall)
    );

    always_comb begin
        st_d      = st_q;
        src       = decode_mode(mode_i);
        ref_ev    = 1'b0;
        new_field = st_q.field;

        // embedded words: V low-to-high is the event, F gives parity
        st_d.emb_ev = 1'b0;
        if (sav_stb_i) begin
            st_d.v_prev = sav_v_i;
            if (sav_v_i && !st_q.v_prev) begin
                st_d.emb_ev = 1'b1;
                st_d.emb_f  = sav_f_i;
            end
        end

        // parity known at the falling sync edge, kept for rising-edge modes
        fid_par = USE_FID_PIN ? fid_lvl : ~st_q.par_fall;
        if (vs_fall) st_d.par_fall = fid_par;

        case (src)
            SRC_VS_FALL: if (vs_fall) begin
                ref_ev    = 1'b1;
                new_field = USE_FID_PIN ? fid_lvl : ~st_q.field;
            end
            SRC_VS_RISE: if (vs_rise) begin
                ref_ev    = 1'b1;
                new_field = st_q.par_fall;
            end
            SRC_EMB: if (st_q.emb_ev) begin
                ref_ev    = 1'b1;
                new_field = st_q.emb_f;
            end
            default: if (fid_rise || fid_fall) begin
                ref_ev    = 1'b1;
                new_field = fid_lvl;
            end
        endcase

        cfg_chg   = (mode_i != st_q.mode) || (std_525_i != st_q.std);
        st_d.mode = mode_i;
        st_d.std  = std_525_i;

        if (ref_ev) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            st_d.field = new_field;
        end else if (line_stb_i && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cfg_chg) st_d.armed = 1'b0;

        st_d.active = st_d.armed &&
            (st_d.cnt == CNT_W'(line_offset(src, std_525_i, st_d.field)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign field_even_o   = st_q.field;
    assign line_cnt_o     = st_q.cnt;
    assign active_start_o = st_q.active;

    AST_EVENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ev |=> (line_cnt_o == '0));                         // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ev && line_stb_i && line_cnt_o != CNT_MAX)
        |=> (line_cnt_o == $past(line_cnt_o) + 1'b1));          // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ev && !line_stb_i) |=> $stable(line_cnt_o));      // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_ev && line_cnt_o == CNT_MAX) |=> (line_cnt_o == CNT_MAX)); // R11

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_start_o && line_stb_i && !ref_ev) |=> !active_start_o); // R5

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !active_start_o);                           // R10

endmodule

// File: tb/vline_anchor_bench.sv
`timescale 1ns/1ps
module vline_anchor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb_i = 1'b0;
    logic       vs_i = 1'b0;
    logic       fid_i = 1'b0;
    logic       sav_stb_i = 1'b0;
    logic       sav_v_i = 1'b0;
    logic       sav_f_i = 1'b0;
    logic [2:0] mode_i = 3'd1;
    logic       std_525_i = 1'b0;
    logic       field_even_o;
    logic [9:0] line_cnt_o;
    logic       active_start_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vline_anchor u_vline_anchor (
        .clk(clk), .rst_n(rst_n), .line_stb_i(line_stb_i),
        .vs_i(vs_i), .fid_i(fid_i), .sav_stb_i(sav_stb_i),
        .sav_v_i(sav_v_i), .sav_f_i(sav_f_i), .mode_i(mode_i),
        .std_525_i(std_525_i), .field_even_o(field_even_o),
        .line_cnt_o(line_cnt_o), .active_start_o(active_start_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_vs(input logic v);
        @(negedge clk); vs_i = v; idle(6);
    endtask

    task automatic set_fid(input logic v);
        @(negedge clk); fid_i = v; idle(6);
    endtask

    task automatic emb_word(input logic v, input logic f);
        @(negedge clk); sav_stb_i = 1'b1; sav_v_i = v; sav_f_i = f;
        @(negedge clk); sav_stb_i = 1'b0;
        idle(3);
    endtask

    task automatic strobe();
        @(negedge clk); line_stb_i = 1'b1;
        @(negedge clk); line_stb_i = 1'b0;
    endtask

    // count is 0 after an event; marker must appear only at exp_line
    task automatic walk_lines(input string req, input int exp_line, input int exp_field);
        chk({req, " field"}, field_even_o, exp_field);
        chk({req, " count after event"}, line_cnt_o, 0);
        for (int i = 1; i <= 30; i++) begin
            strobe();
            chk({req, " count"}, line_cnt_o, i);
            chk({req, " marker"}, active_start_o, (i == exp_line) ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        chk("R12 count", line_cnt_o, 0);
        chk("R12 field", field_even_o, 0);
        chk("R12 marker", active_start_o, 0);
        for (int i = 1; i <= 30; i++) begin
            strobe();
            chk("R12 no marker before event", active_start_o, 0);
        end
    endtask

    task automatic t_vs_fall();
        mode_i = 3'd1; std_525_i = 1'b0; idle(2);
        set_fid(1'b0); set_vs(1'b1); set_vs(1'b0);
        walk_lines("R8 R2 fall 625 odd", 24, 0);
        set_fid(1'b1); set_vs(1'b1); set_vs(1'b0);
        walk_lines("R8 R2 fall 625 even", 25, 1);
        mode_i = 3'd3; std_525_i = 1'b1; idle(2);
        set_vs(1'b1); set_vs(1'b0);
        walk_lines("R3 R1 fall 525 even", 22, 1);
        set_fid(1'b0); set_vs(1'b1); set_vs(1'b0);
        walk_lines("R3 fall 525 odd", 22, 0);
    endtask

    task automatic t_vs_rise();
        mode_i = 3'd0; std_525_i = 1'b0; idle(2);
        set_fid(1'b1); set_vs(1'b1); set_vs(1'b0); set_vs(1'b1);
        walk_lines("R9 R2 rise 625 even", 22, 1);
        set_fid(1'b0); set_vs(1'b0); set_fid(1'b1); set_vs(1'b1);
        walk_lines("R9 R2 rise 625 parity from falling edge", 21, 0);
        mode_i = 3'd4; std_525_i = 1'b1; idle(2);
        set_vs(1'b0); set_vs(1'b1);
        walk_lines("R3 R1 rise 525 even", 19, 1);
        set_fid(1'b0); set_vs(1'b0); set_vs(1'b1);
        walk_lines("R3 rise 525 odd", 18, 0);
    endtask

    task automatic t_fid();
        mode_i = 3'd6; std_525_i = 1'b0; idle(2);
        set_fid(1'b1);
        walk_lines("R7 R2 fid 625 even", 16, 1);
        set_fid(1'b0);
        walk_lines("R7 R2 fid 625 odd", 15, 0);
        std_525_i = 1'b1; idle(2);
        set_fid(1'b1);
        walk_lines("R7 R3 fid 525 even", 13, 1);
        set_fid(1'b0);
        walk_lines("R7 R3 fid 525 odd", 12, 0);
    endtask

    task automatic t_emb();
        mode_i = 3'd7; std_525_i = 1'b0; idle(2);
        emb_word(1'b0, 1'b1); emb_word(1'b1, 1'b0);
        walk_lines("R6 R2 emb 625 odd", 15, 0);
        emb_word(1'b1, 1'b1);
        chk("R6 repeated V=1 no reset", line_cnt_o, 30);
        chk("R6 repeated V=1 field kept", field_even_o, 0);
        emb_word(1'b0, 1'b1); emb_word(1'b1, 1'b1);
        walk_lines("R6 R2 emb 625 even", 16, 1);
        std_525_i = 1'b1; idle(2);
        emb_word(1'b0, 1'b0); emb_word(1'b1, 1'b0);
        walk_lines("R6 R3 emb 525 odd", 12, 0);
        emb_word(1'b0, 1'b1); emb_word(1'b1, 1'b1);
        walk_lines("R6 R3 emb 525 even", 13, 1);
    endtask

    task automatic t_cfg_change();
        mode_i = 3'd1; std_525_i = 1'b0; idle(2);
        set_fid(1'b0); set_vs(1'b1); set_vs(1'b0);
        for (int i = 1; i <= 10; i++) strobe();
        chk("R10 count before change", line_cnt_o, 10);
        mode_i = 3'd5; idle(2);
        for (int i = 11; i <= 30; i++) begin
            strobe();
            chk("R10 marker held off", active_start_o, 0);
        end
        set_vs(1'b1); set_vs(1'b0);
        walk_lines("R10 re-armed by event", 24, 0);
    endtask

    task automatic t_saturate();
        set_vs(1'b1); set_vs(1'b0);
        @(negedge clk); line_stb_i = 1'b1;
        idle(1030);
        line_stb_i = 1'b0;
        @(negedge clk);
        chk("R11 count saturates", line_cnt_o, 1023);
        chk("R11 no marker at saturation", active_start_o, 0);
        strobe();
        chk("R11 stays at max", line_cnt_o, 1023);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_vs_fall();
        t_vs_rise();
        t_fid();
        t_emb();
        t_cfg_change();
        t_saturate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule